// File: doc/BRIEF.md
# Supervisory Reset Generator with Manual Reset

This block turns supply-monitor flags and a manual-reset pin into the active-low reset for a processor. The analog comparators live elsewhere; the block sees only their digital results. Those results arrive asynchronously and are resynchronised inside the block. The processor reset falls as soon as the supply-low flag is set or a qualified manual-reset press is seen. It stays low while either cause persists. After the last cause clears, it is held for a fixed release delay, nominally 200 ms. The same delay applies after supply recovery and after the button is released.

A manual-reset press must last a minimum time, nominally 25 µs, to be accepted; shorter glitches are discarded. An accepted press emits a one-cycle clear pulse that neighbouring supervisory logic, such as a watchdog, uses to clear its counters and return its outputs to the idle state. The block also exports two signals for other supervisory blocks, for example a battery check. One is a level that is high for the whole release window. The other is a one-cycle strobe at the end of that window. A separate low-line flag is resynchronised and driven out inverted as an early-warning output, unrelated to the reset timing. A battery-switchover condition has no input here and so cannot influence reset.

All delays are given in microseconds and converted to clock cycles from a clock-frequency parameter, which must be a whole number of MHz.

Top module: `rst_supervisor`

## Requirements
- R1: `cpu_rst_n_o` is 0 from the third clock edge after `supply_low_i` rises and stays 0 while `supply_low_i` is 1. When both causes are active, the release delay counts from the later one to clear.
- R2: With HOLD_CYC = (CLK_HZ/1e6)·HOLD_US, `tmo_active_o` rises on the third edge after the supply-low flag falls and stays 1 for exactly HOLD_CYC cycles. `cpu_rst_n_o` rises in the cycle `tmo_active_o` falls.
- R3: While a qualified manual reset is held, `cpu_rst_n_o` stays 0 however long that lasts. The release window starts on the fourth edge after `mr_n_i` returns to 1.
- R4: With MR_MIN_CYC = (CLK_HZ/1e6)·MR_MIN_US, a low level on `mr_n_i` lasting MR_MIN_CYC cycles or more is accepted and asserts reset. A shorter low has no effect on any output.
- R5: `cnt_clr_o` is a single-cycle pulse in the cycle a manual-reset press is accepted (MR_MIN_CYC+2 edges after the fall of `mr_n_i`). `cpu_rst_n_o` is 0 from the next cycle.
- R6: `lowline_n_o` is the inverse of `lowline_i` delayed by two edges. It is 1 during logic reset and does not affect or depend on reset timing.
- R7: A supply-low event during the release window ends the window at once and keeps reset low. A full HOLD_CYC window restarts from zero after the flag clears again.
- R8: `tmo_done_o` is 1 for exactly one cycle, the first cycle in which `cpu_rst_n_o` is 1 after a release window.
- R9: While `rst_n` is 0, `cpu_rst_n_o` is 0 and `tmo_active_o` is 1. After `rst_n` rises, a full HOLD_CYC window elapses before `cpu_rst_n_o` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low logic reset (power-on) |
| supply_low_i | input | 1 | Asynchronous flag, 1 while the supply is below the reset threshold |
| mr_n_i | input | 1 | Asynchronous manual-reset pin, active low |
| lowline_i | input | 1 | Asynchronous flag, 1 while the supply is near the reset threshold |
| cpu_rst_n_o | output | 1 | Processor reset, active low |
| lowline_n_o | output | 1 | Early-warning output, active low |
| tmo_active_o | output | 1 | High throughout the release window |
| tmo_done_o | output | 1 | One-cycle strobe at the end of the release window |
| cnt_clr_o | output | 1 | One-cycle clear pulse on an accepted manual reset |

## Verification
The assertions assume that each asynchronous flag holds each level for at least the two cycles the synchroniser needs, so the filtered and timed states follow the pin one level at a time without a lost edge. They also assume that a manual-reset press and a supply event may overlap in any order. The stimulus changes inputs only between clock edges and holds every level for whole cycles. It uses press lengths one below, equal to and far above the minimum, and overlapping supply and button events. Expected values are counted in cycles from the edge at which each input changes.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_TIME = 2'd1,
    ST_RUN  = 2'd2
  } rst_state_e;

  function automatic int cyc_of_us(input int hz, input int us);
    return (hz / 1000000) * us;
  endfunction

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
  parameter int              WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] meta_q, meta_d;
  logic [WIDTH-1:0] out_q, out_d;

  always_comb begin
    meta_d = d_i;
    out_d  = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      out_q  <= RST_VAL;
    end else begin
      meta_q <= meta_d;
      out_q  <= out_d;
    end
  end

  assign q_o = out_q;

endmodule

// File: rtl/rsup_mr_filter.sv
module rsup_mr_filter #(
  parameter int MIN_CYC = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr_n_s,
  output logic mr_act_o,
  output logic clr_o
);

  localparam int             CW   = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0]  LAST = CW'(MIN_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          act_q, act_d;
  logic          clr_q, clr_d;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    act_d  = act_q;
    clr_d  = 1'b0;
    if (mr_n_s) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
      act_d  = 1'b0;
    end else if (!act_q) begin
      if (cnt_q == LAST) begin
        act_d = 1'b1;
        clr_d = 1'b1;
      end else begin
        cnt_d  = cnt_q + CW'(1);
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      act_q <= act_d;
      clr_q <= clr_d;
    end
  end

  assign mr_act_o = act_q;
  assign clr_o    = clr_q;

  // R4
  mr_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> $past(!mr_n_s))
    else $error("press accepted without a low pin");

  // R5
  clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> !clr_q)
    else $error("clear pulse longer than one cycle");

endmodule

// File: rtl/rsup_timer.sv
module rsup_timer
  import rsup_pkg::*;
#(
  parameter int HOLD_CYC = 10000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  output logic rst_n_o,
  output logic active_o,
  output logic done_o
);

  localparam int            TW   = $clog2(HOLD_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(HOLD_CYC - 1);

  rst_state_e    state_q, state_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    done_d  = 1'b0;
    if (hold_i) begin
      state_d = ST_HOLD;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else begin
      case (state_q)
        ST_HOLD: begin
          state_d = ST_TIME;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
        ST_TIME: begin
          if (cnt_q == LAST) begin
            state_d = ST_RUN;
            done_d  = 1'b1;
          end else begin
            cnt_d  = cnt_q + TW'(1);
            cnt_en = 1'b1;
          end
        end
        ST_RUN:  state_d = ST_RUN;
        default: state_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_TIME;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign rst_n_o  = (state_q == ST_RUN);
  assign active_o = (state_q == ST_TIME);
  assign done_o   = done_q;

  // R1
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> !rst_n_o)
    else $error("reset not asserted under a hold cause");

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && hold_i) |=> (!active_o && !rst_n_o))
    else $error("window not ended by a new hold cause");

  // R2
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n_o) |-> $past(active_o))
    else $error("reset released without a window");

  // R8
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (rst_n_o && $past(active_o)))
    else $error("end strobe outside release");

  // R8
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o)
    else $error("end strobe longer than one cycle");

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rsup_pkg::*;
#(
  parameter int CLK_HZ    = 50000000,
  parameter int HOLD_US   = 200000,
  parameter int MR_MIN_US = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low_i,
  input  logic mr_n_i,
  input  logic lowline_i,
  output logic cpu_rst_n_o,
  output logic lowline_n_o,
  output logic tmo_active_o,
  output logic tmo_done_o,
  output logic cnt_clr_o
);

  localparam int HOLD_CYC   = cyc_of_us(CLK_HZ, HOLD_US);
  localparam int MR_MIN_CYC = cyc_of_us(CLK_HZ, MR_MIN_US);

  localparam int IDX_SUP = 2;
  localparam int IDX_MR  = 1;
  localparam int IDX_LL  = 0;

  logic [2:0] raw_in, syn_in;
  logic       mr_act;
  logic       hold;

  assign raw_in = {supply_low_i, mr_n_i, lowline_i};

  rsup_sync #(
    .WIDTH   (3),
    .RST_VAL (3'b010)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  rsup_mr_filter #(
    .MIN_CYC (MR_MIN_CYC)
  ) u_mr (
    .clk      (clk),
    .rst_n    (rst_n),
    .mr_n_s   (syn_in[IDX_MR]),
    .mr_act_o (mr_act),
    .clr_o    (cnt_clr_o)
  );

  assign hold = syn_in[IDX_SUP] | mr_act;

  rsup_timer #(
    .HOLD_CYC (HOLD_CYC)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_i   (hold),
    .rst_n_o  (cpu_rst_n_o),
    .active_o (tmo_active_o),
    .done_o   (tmo_done_o)
  );

  assign lowline_n_o = ~syn_in[IDX_LL];

  // R5
  clr_then_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_o |=> !cpu_rst_n_o)
    else $error("accepted press did not assert reset");

  // R8
  done_not_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_done_o |-> !tmo_active_o)
    else $error("end strobe inside window");

endmodule

// File: tb/rst_supervisor_test.sv
module rst_supervisor_test;

  localparam int CLK_HZ = 1000000;
  localparam int HUS    = 40;
  localparam int MUS    = 5;
  localparam int H      = HUS;
  localparam int M      = MUS;

  localparam int SIG_RST = 0;
  localparam int SIG_ACT = 1;
  localparam int SIG_DON = 2;
  localparam int SIG_CLR = 3;
  localparam int SIG_LL  = 4;

  typedef struct {
    int    at;
    int    sig;
    logic  val;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_low = 1'b0;
  logic mr_n = 1'b1;
  logic lowline = 1'b0;
  logic cpu_rst_n, lowline_n, tmo_active, tmo_done, cnt_clr;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;
  exp_t sb[$];

  always #10 clk = ~clk;

  rst_supervisor #(
    .CLK_HZ    (CLK_HZ),
    .HOLD_US   (HUS),
    .MR_MIN_US (MUS)
  ) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_low_i (supply_low),
    .mr_n_i       (mr_n),
    .lowline_i    (lowline),
    .cpu_rst_n_o  (cpu_rst_n),
    .lowline_n_o  (lowline_n),
    .tmo_active_o (tmo_active),
    .tmo_done_o   (tmo_done),
    .cnt_clr_o    (cnt_clr)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc = 0;
    else        cyc = cyc + 1;
  end

  function automatic logic pick(input int sig);
    case (sig)
      SIG_RST: return cpu_rst_n;
      SIG_ACT: return tmo_active;
      SIG_DON: return tmo_done;
      SIG_CLR: return cnt_clr;
      default: return lowline_n;
    endcase
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic expect_at(input int at, input int sig, input logic val, input string tag);
    exp_t it;
    int   pos;
    it.at = at; it.sig = sig; it.val = val; it.tag = tag;
    pos = sb.size();
    for (int i = 0; i < sb.size(); i++) begin
      if (sb[i].at > at) begin
        pos = i;
        break;
      end
    end
    sb.insert(pos, it);
  endtask

  // monitor: pops expected items in their cycle and compares
  always @(negedge clk) begin
    if (rst_n) begin
      while (sb.size() > 0 && sb[0].at <= cyc) begin
        exp_t it;
        it = sb.pop_front();
        if (it.at < cyc) begin
          n_chk++;
          n_fail++;
          $display("FAIL %s: sample at cycle %0d missed (now %0d), expected %b",
                   it.tag, it.at, cyc, it.val);
        end else begin
          check(pick(it.sig), it.val, it.tag);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
    step(3);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual running expected done");
    finish_run();
  end

  initial begin
    int c, d, e, f, r, s;

    // R9 / R6: state during logic reset
    step(4);
    check(cpu_rst_n, 1'b0, "R9 reset held during logic reset");
    check(tmo_active, 1'b1, "R9 window level during logic reset");
    check(lowline_n, 1'b1, "R6 lowline idle during logic reset");
    check(cnt_clr, 1'b0, "R5 no clear during logic reset");

    // R9: full delay after power-on
    expect_at(H - 1, SIG_RST, 1'b0, "R9 still in reset at H-1");
    expect_at(H - 1, SIG_ACT, 1'b1, "R9 window open at H-1");
    expect_at(H,     SIG_RST, 1'b1, "R9 release at H");
    expect_at(H,     SIG_ACT, 1'b0, "R9 window closed at H");
    expect_at(H,     SIG_DON, 1'b1, "R8 strobe at power-on release");
    expect_at(H + 1, SIG_DON, 1'b0, "R8 strobe one cycle");
    rst_n = 1'b1;
    drain();

    // R1 / R2 / R8: supply dip
    c = cyc;
    supply_low = 1'b1;
    expect_at(c + 2, SIG_RST, 1'b1, "R1 not before third edge");
    expect_at(c + 3, SIG_RST, 1'b0, "R1 asserted on third edge");
    expect_at(c + 3, SIG_ACT, 1'b0, "R1 no window while low");
    step(10);
    d = cyc;
    supply_low = 1'b0;
    expect_at(d + 2,     SIG_ACT, 1'b0, "R2 window not early");
    expect_at(d + 3,     SIG_ACT, 1'b1, "R2 window opens");
    expect_at(d + 2 + H, SIG_RST, 1'b0, "R2 held through window");
    expect_at(d + 2 + H, SIG_DON, 1'b0, "R8 no early strobe");
    expect_at(d + 3 + H, SIG_RST, 1'b1, "R2 release after HOLD_CYC");
    expect_at(d + 3 + H, SIG_ACT, 1'b0, "R2 window closes");
    expect_at(d + 3 + H, SIG_DON, 1'b1, "R8 strobe at release");
    expect_at(d + 4 + H, SIG_DON, 1'b0, "R8 strobe single cycle");
    drain();

    // R7: supply dip inside the window restarts it
    c = cyc;
    supply_low = 1'b1;
    step(10);
    d = cyc;
    supply_low = 1'b0;
    step(20);
    e = cyc;
    supply_low = 1'b1;
    expect_at(e + 3,     SIG_ACT, 1'b0, "R7 window ended by dip");
    expect_at(d + 3 + H, SIG_RST, 1'b0, "R7 no release at old end");
    step(4);
    f = cyc;
    supply_low = 1'b0;
    expect_at(f + 3,     SIG_ACT, 1'b1, "R7 window reopens");
    expect_at(f + 2 + H, SIG_RST, 1'b0, "R7 full window from zero");
    expect_at(f + 3 + H, SIG_RST, 1'b1, "R7 release after restart");
    drain();

    // R4: press one cycle too short is ignored
    c = cyc;
    mr_n = 1'b0;
    expect_at(c + M + 2, SIG_CLR, 1'b0, "R4 short press no clear");
    expect_at(c + M + 3, SIG_RST, 1'b1, "R4 short press no reset");
    expect_at(c + M + 8, SIG_RST, 1'b1, "R4 short press still no reset");
    expect_at(c + M + 8, SIG_ACT, 1'b0, "R4 short press no window");
    step(M - 1);
    mr_n = 1'b1;
    drain();

    // R4 / R5 / R3: press of exactly the minimum length
    c = cyc;
    mr_n = 1'b0;
    expect_at(c + M + 1, SIG_CLR, 1'b0, "R5 clear not early");
    expect_at(c + M + 2, SIG_CLR, 1'b1, "R5 clear on acceptance");
    expect_at(c + M + 3, SIG_CLR, 1'b0, "R5 clear single cycle");
    expect_at(c + M + 3, SIG_RST, 1'b0, "R4 minimum press asserts reset");
    expect_at(c + M + 3 + H, SIG_RST, 1'b0, "R3 held through window");
    expect_at(c + M + 4 + H, SIG_RST, 1'b1, "R3 release after press");
    step(M);
    mr_n = 1'b1;
    drain();

    // R3: long press holds reset, window starts on release
    c = cyc;
    mr_n = 1'b0;
    expect_at(c + M + 2,      SIG_CLR, 1'b1, "R5 clear on long press");
    expect_at(c + M + 3,      SIG_RST, 1'b0, "R3 reset on long press");
    expect_at(c + M + 13 + H, SIG_RST, 1'b0, "R3 held past a window length");
    step(H + 20);
    r = cyc;
    mr_n = 1'b1;
    expect_at(r + 3,     SIG_ACT, 1'b0, "R3 no window before release");
    expect_at(r + 4,     SIG_ACT, 1'b1, "R3 window on fourth edge");
    expect_at(r + 3 + H, SIG_RST, 1'b0, "R3 held through window");
    expect_at(r + 4 + H, SIG_RST, 1'b1, "R3 release");
    drain();

    // R1: overlapping causes, delay counts from the later one
    c = cyc;
    mr_n = 1'b0;
    supply_low = 1'b1;
    step(10);
    r = cyc;
    mr_n = 1'b1;
    expect_at(r + 4 + H, SIG_RST, 1'b0, "R1 supply still holds reset");
    step(20);
    s = cyc;
    supply_low = 1'b0;
    expect_at(s + 2 + H, SIG_RST, 1'b0, "R1 window from later cause");
    expect_at(s + 3 + H, SIG_RST, 1'b1, "R1 release after later cause");
    drain();

    // R6: low-line warning independent of reset
    c = cyc;
    lowline = 1'b1;
    expect_at(c + 1, SIG_LL,  1'b1, "R6 warning not early");
    expect_at(c + 2, SIG_LL,  1'b0, "R6 warning after two edges");
    expect_at(c + 5, SIG_RST, 1'b1, "R6 warning leaves reset alone");
    expect_at(c + 5, SIG_ACT, 1'b0, "R6 warning opens no window");
    step(8);
    d = cyc;
    lowline = 1'b0;
    expect_at(d + 1, SIG_LL, 1'b0, "R6 clear not early");
    expect_at(d + 2, SIG_LL, 1'b1, "R6 clear after two edges");
    drain();

    finish_run();
  end

endmodule